// File: doc/BRIEF.md
# Countdown Watchdog with Register Bus

This block is a watchdog built on one countdown channel. Software reaches it over a plain 32-bit register bus: an address, a write strobe, write data and read data that is valid in the same cycle. Software writes a start value and sets two enable bits in a control word that is shared with a wider timer bank. The block then counts down at half the bus clock rate. Software must write the kick register before the count runs out.

When the count reaches zero while the channel is running, the block latches an expiry flag. It sends a single-cycle reset request to the system and raises a level interrupt if the interrupt enable bit in the control word is set. It then stays at zero until software restarts the count. Software restarts the count by kicking, by re-enabling the channel, or by writing a new start value while the channel runs.

Top module: `kick_watchdog`

## Requirements
- R1: The control word at offset 0x00 stores and reads back all 32 bits. Counting needs both bit 25 (watchdog enable) and bit 5 (channel enable) set. Other bits have no effect on the count or the outputs, except bit 21, which gates the interrupt.
- R2: The start-value register at offset 0x2C stores and reads back a full 32-bit value.
- R3: The present count is readable at offset 0x30 at any time. Writes to that offset are ignored.
- R4: While both enables are set and the count is not zero, the count drops by one on every second clock edge. The first drop comes on the second edge after the edge that started the count.
- R5: The count is loaded from the start value on three events: on the edge where the run condition becomes true, on a write to 0x2C while running (the new value is used), and on a kick.
- R6: Clearing either enable bit freezes the count at the very edge of that write, and it stays frozen while disabled.
- R7: Writing 0x38 with bit 0 set is a kick. It reloads the count and clears the expiry flag. A write to 0x38 with bit 0 clear does nothing, and 0x38 always reads 0.
- R8: On the first edge where the count is zero while running, status bit 0 at offset 0x3C sets and stays set until a kick. In that same step, `rst_req` goes high for exactly one cycle. The count then stays at zero until a restart from R5.
- R9: `irq` is high exactly when the expiry flag is set and control bit 21 is set.
- R10: Writes to unmapped offsets and to 0x3C are ignored. Reads from unmapped offsets return 0.
- R11: After reset, every register and count reads 0, and `irq` and `rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Expiry interrupt (level) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Read data is combinational from the address, so it is checked in the same cycle the address is driven. A write shows up in the register state after the next rising edge. The first decrement lands two edges after the starting edge. The expiry flag, the interrupt and the reset pulse appear one edge after the count first shows zero. The bench drives each cycle at the falling edge and checks one time unit later. Its cycle model advances exactly once per rising edge, so every expected value matches the cycle in which the result is due.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_LOAD  = 'h2C;
    localparam int OFF_COUNT = 'h30;
    localparam int OFF_KICK  = 'h38;
    localparam int OFF_STAT  = 'h3C;

    localparam int BIT_WD_EN  = 25;
    localparam int BIT_IRQ_EN = 21;
    localparam int BIT_CH_EN  = 5;
    localparam int BIT_KICK   = 0;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_q,
    input  logic              expired_q,
    output logic [DATA_W-1:0] load_d,
    output logic [DATA_W-1:0] rdata,
    output logic              run_q,
    output logic              run_d,
    output logic              irq_en,
    output logic              kick,
    output logic              load_wr
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] load;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_ctrl, sel_load, sel_count, sel_kick, sel_stat;

    always_comb begin
        sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
        sel_load  = (addr == ADDR_W'(OFF_LOAD));
        sel_count = (addr == ADDR_W'(OFF_COUNT));
        sel_kick  = (addr == ADDR_W'(OFF_KICK));
        sel_stat  = (addr == ADDR_W'(OFF_STAT));

        r_d = r_q;
        if (we && sel_ctrl) r_d.ctrl = wdata;
        if (we && sel_load) r_d.load = wdata;

        rdata = '0;
        if (sel_ctrl)  rdata = r_q.ctrl;
        if (sel_load)  rdata = r_q.load;
        if (sel_count) rdata = count_q;
        if (sel_stat)  rdata = DATA_W'(expired_q);
        if (sel_kick)  rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign load_d  = r_d.load;
    assign run_q   = r_q.ctrl[BIT_WD_EN] & r_q.ctrl[BIT_CH_EN];
    assign run_d   = r_d.ctrl[BIT_WD_EN] & r_d.ctrl[BIT_CH_EN];
    assign irq_en  = r_q.ctrl[BIT_IRQ_EN];
    assign kick    = we & sel_kick & wdata[BIT_KICK];
    assign load_wr = we & sel_load;
endmodule

// File: rtl/kwd_tick.sv
module kwd_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tick
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (clear)        ph_d = '0;
        else if (advance) ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
        tick = advance & ~clear & (ph_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/kwd_core.sv
module kwd_core #(
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_q,
    input  logic              run_d,
    input  logic              kick,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_d,
    output logic [DATA_W-1:0] count_q,
    output logic              expired_q,
    output logic              pulse_q
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic              halted;
        logic              expired;
        logic              pulse;
    } core_t;

    core_t s_d, s_q;
    logic  active, restart, at_zero, tick, clr_phase;

    always_comb begin
        active    = run_q & run_d & ~s_q.halted;
        restart   = kick | (run_d & ~run_q) | (load_wr & run_d);
        at_zero   = (s_q.count == '0);
        clr_phase = restart | ~active | at_zero;
    end

    kwd_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr_phase),
        .advance (active & ~at_zero),
        .tick    (tick)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (restart) begin
            s_d.count  = load_d;
            s_d.halted = 1'b0;
            if (kick) s_d.expired = 1'b0;
        end else if (active && at_zero) begin
            s_d.halted  = 1'b1;
            s_d.expired = 1'b1;
            s_d.pulse   = 1'b1;
        end else if (tick) begin
            s_d.count = s_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_q   = s_q.count;
    assign expired_q = s_q.expired;
    assign pulse_q   = s_q.pulse;
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    logic [DATA_W-1:0] count_q, load_d;
    logic              expired_q, run_q, run_d, irq_en, kick, load_wr;

    kwd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .count_q   (count_q),
        .expired_q (expired_q),
        .load_d    (load_d),
        .rdata     (bus_rdata),
        .run_q     (run_q),
        .run_d     (run_d),
        .irq_en    (irq_en),
        .kick      (kick),
        .load_wr   (load_wr)
    );

    kwd_core #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_q     (run_q),
        .run_d     (run_d),
        .kick      (kick),
        .load_wr   (load_wr),
        .load_d    (load_d),
        .count_q   (count_q),
        .expired_q (expired_q),
        .pulse_q   (rst_req)
    );

    assign irq = expired_q & irq_en;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              rst_req,
    input logic              irq_en,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] load_d,
    input logic              expired_q,
    input logic              run_q,
    input logic              run_d,
    input logic              kick,
    input logic              load_wr
);
    logic unmapped;
    assign unmapped = (bus_addr != ADDR_W'(OFF_CTRL))  && (bus_addr != ADDR_W'(OFF_LOAD)) &&
                      (bus_addr != ADDR_W'(OFF_COUNT)) && (bus_addr != ADDR_W'(OFF_KICK)) &&
                      (bus_addr != ADDR_W'(OFF_STAT));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    a_r8_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> expired_q);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_q && !kick) |=> expired_q);
    a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(expired_q) || $rose(irq_en)));
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_d && !kick) |=> $stable(count_q));
    a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && run_d && !kick && !load_wr) |=>
            (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));
    a_r5_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count_q == $past(load_d)));
    a_r7_kick_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_KICK)) |-> (bus_rdata == '0));
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));
endmodule

bind kick_watchdog kwd_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rst_req   (rst_req),
    .irq_en    (irq_en),
    .count_q   (count_q),
    .load_d    (load_d),
    .expired_q (expired_q),
    .run_q     (run_q),
    .run_d     (run_d),
    .kick      (kick),
    .load_wr   (load_wr)
);

// File: tb/tb_kick_watchdog.sv
module tb_kick_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ctrl = '0, m_load = '0, m_cnt = '0;
    bit          m_ph = 0, m_halt = 0, m_exp = 0, m_pulse = 0;

    localparam logic [31:0] EN_BOTH = (32'd1 << 25) | (32'd1 << 5);
    localparam logic [31:0] IRQ_EN  = (32'd1 << 21);

    always #2 clk = ~clk;

    kick_watchdog dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_ctrl;
            8'h2C:   return m_load;
            8'h30:   return m_cnt;
            8'h3C:   return {31'b0, m_exp};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R1";
            8'h2C:   return "R2";
            8'h30:   return "R4";
            8'h38:   return "R7";
            8'h3C:   return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input logic we, input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] nc, nl;
        bit run, nrun, kk, rs, act;
        nc = m_ctrl; nl = m_load;
        if (we && a == 8'h00) nc = wd;
        if (we && a == 8'h2C) nl = wd;
        run  = m_ctrl[25] && m_ctrl[5];
        nrun = nc[25] && nc[5];
        kk   = we && a == 8'h38 && wd[0];
        rs   = kk || (nrun && !run) || (we && a == 8'h2C && nrun);
        act  = run && nrun && !m_halt;
        m_pulse = 0;
        if (rs) begin
            m_cnt = nl; m_ph = 0; m_halt = 0;
            if (kk) m_exp = 0;
        end else if (act && m_cnt == 0) begin
            m_halt = 1; m_exp = 1; m_pulse = 1; m_ph = 0;
        end else if (act) begin
            if (m_ph) begin m_cnt = m_cnt - 1; m_ph = 0; end
            else m_ph = 1;
        end else begin
            m_ph = 0;
        end
        m_ctrl = nc; m_load = nl;
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] wd, input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd;
        #1;
        chk("R9 irq", {31'b0, irq}, {31'b0, m_exp && m_ctrl[21]});
        chk("R8 rst_req", {31'b0, rst_req}, {31'b0, m_pulse});
        if (!we) chk((tag != "") ? tag : tag_of(a), bus_rdata, model_read(a));
        model_step(we, a, wd);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk("R11 irq", {31'b0, irq}, 32'd0);
        chk("R11 rst_req", {31'b0, rst_req}, 32'd0);
        rst_n = 1'b1;
        cyc(0, 8'h00, 0, "R11");
        cyc(0, 8'h2C, 0, "R11");
        cyc(0, 8'h30, 0, "R11");
        cyc(0, 8'h3C, 0, "R11");

        // start value, ignored write to the count, then run with interrupt
        cyc(1, 8'h2C, 32'd6, "");
        cyc(0, 8'h2C, 0, "R2");
        cyc(1, 8'h30, 32'h55, "");
        cyc(0, 8'h30, 0, "R3");
        cyc(1, 8'h00, EN_BOTH | IRQ_EN | 32'h3, "");
        cyc(0, 8'h00, 0, "R1");
        for (int i = 0; i < 16; i++) cyc(0, 8'h30, 0, "R4");
        cyc(0, 8'h3C, 0, "R8");

        // kick: reload and clear
        cyc(1, 8'h38, 32'd1, "");
        cyc(0, 8'h38, 0, "R7");
        cyc(0, 8'h3C, 0, "R7");
        for (int i = 0; i < 5; i++) cyc(0, 8'h30, 0, "R4");

        // freeze by dropping the channel enable
        cyc(1, 8'h00, 32'd1 << 25, "");
        for (int i = 0; i < 6; i++) cyc(0, 8'h30, 0, "R6");
        cyc(1, 8'h00, EN_BOTH, "");
        cyc(0, 8'h30, 0, "R5");
        cyc(0, 8'h30, 0, "R5");
        cyc(1, 8'h2C, 32'd3, "");
        cyc(0, 8'h30, 0, "R5");

        // kick with bit 0 clear, unmapped and status writes
        cyc(1, 8'h38, 32'hFFFF_FFFE, "");
        cyc(0, 8'h30, 0, "R7");
        cyc(1, 8'h10, 32'hFFFF_FFFF, "");
        cyc(1, 8'h3C, 32'hFFFF_FFFF, "");
        cyc(0, 8'h10, 0, "R10");
        cyc(0, 8'h3C, 0, "R10");
        cyc(0, 8'h00, 0, "R10");
        for (int i = 0; i < 12; i++) cyc(0, 8'h30, 0, "R8");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] v;
            logic [7:0]  a;
            r = int'($urandom % 100);
            if (r < 60) begin
                case ($urandom % 6)
                    0: a = 8'h00; 1: a = 8'h2C; 2: a = 8'h30;
                    3: a = 8'h38; 4: a = 8'h3C; default: a = 8'($urandom);
                endcase
                cyc(0, a, 0, "");
            end else if (r < 68) begin
                v = $urandom;
                if ($urandom % 4 != 0) v = v | EN_BOTH;
                cyc(1, 8'h00, v, "");
            end else if (r < 80) begin
                cyc(1, 8'h2C, $urandom % 12, "");
            end else if (r < 90) begin
                cyc(1, 8'h38, $urandom, "");
            end else begin
                cyc(1, 8'($urandom), $urandom, "");
            end
        end
        report();
    end
endmodule